// File: doc/BRIEF.md
# Command-Gated Shared Byte Queue

This block is one byte-wide first-in first-out queue that two parties share: a host register port and an internal command engine. The host pushes a byte by writing the data register and pops one by reading that same register. A length output shows how many bytes are held. One queue carries traffic in both directions, so the block only lets the host write or read while a command that needs that direction is active. Any other host access is refused.

The engine has its own push and pop strobes. They work under every command, so the engine can feed or drain the queue while a command runs. When the engine and the host touch the queue in the same cycle, the engine wins. The host access is dropped and recorded in a sticky conflict flag. A flush input empties the queue in one cycle.

Top module: `shfifo_top`

## Requirements
- R1: After reset, `fifo_len` is 0 and both `overflow` and `conflict` are 0.
- R2: The command code is 3 bits: 0 idle, 1 startup, 2 transmit, 3 receive, 4 transceive, 5 non-volatile write, and 6 and 7 are unused. A host write stores a byte only under codes 2, 4 or 5. Under any other code the write is dropped and `overflow` is set.
- R3: A host read pops a byte only under codes 3 or 4. Under any other code `host_rdata` is 00h and the length does not change.
- R4: Bytes leave the queue in the order they entered it. A granted host read shows the oldest byte on `host_rdata` combinationally, in the same cycle as the read strobe.
- R5: `fifo_len` equals the number of stored bytes. It reaches DEPTH (64) when the queue is full.
- R6: A host write or engine push while the queue is full is dropped and sets `overflow`. The flag stays set until a flush.
- R7: A granted host read of an empty queue returns 00h and leaves the length at 0 without setting any flag.
- R8: Engine push and pop take effect under every command code, including idle. `eng_rdata` always shows the oldest byte, or 00h when the queue is empty.
- R9: When `eng_push` or `eng_pop` is high, a host read or write in the same cycle has no effect on the queue and sets the sticky `conflict` flag.
- R10: A flush empties the queue and clears `overflow` and `conflict` by the next cycle. Any access in the flush cycle is ignored.
- R11: Ordering holds when the pointers wrap past the end of storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empty the queue and clear flags |
| cmd | input | 3 | Active command code |
| host_wr | input | 1 | Host write strobe to data register |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe from data register |
| host_rdata | output | 8 | Host read byte (00h if not granted or empty) |
| eng_push | input | 1 | Engine push strobe |
| eng_wdata | input | 8 | Engine push byte |
| eng_pop | input | 1 | Engine pop strobe |
| eng_rdata | output | 8 | Oldest byte for the engine |
| fifo_len | output | 7 | Number of stored bytes |
| overflow | output | 1 | Sticky dropped-write flag |
| conflict | output | 1 | Sticky host-access-lost flag |

## Verification
The bench builds the block with its default 64-entry, 8-bit configuration. With that size, a run of 64 writes reaches the exact full boundary, where the length reads 64 and the next write overflows. Pushing 80 bytes through the queue in two batches of 40 drives both pointers past the end of storage, which exercises the wrap. Every one of the eight command codes is tried against both host directions.

// File: rtl/shfifo_pkg.sv
package shfifo_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE    = 3'd0,
        CMD_STARTUP = 3'd1,
        CMD_TX      = 3'd2,
        CMD_RX      = 3'd3,
        CMD_TXRX    = 3'd4,
        CMD_NVWRITE = 3'd5,
        CMD_RSVD6   = 3'd6,
        CMD_RSVD7   = 3'd7
    } cmd_e;

    function automatic logic host_may_write(cmd_e c);
        return (c == CMD_TX) || (c == CMD_TXRX) || (c == CMD_NVWRITE);
    endfunction

    function automatic logic host_may_read(cmd_e c);
        return (c == CMD_RX) || (c == CMD_TXRX);
    endfunction

endpackage

// File: rtl/shfifo_gate.sv
module shfifo_gate
    import shfifo_pkg::*;
(
    input  logic [2:0] cmd,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic       eng_push,
    input  logic       eng_pop,
    output logic       wr_try,
    output logic       rd_try,
    output logic       wr_perm,
    output logic       rd_perm,
    output logic       lost
);
    logic eng_act;

    always_comb begin
        eng_act = eng_push | eng_pop;
        wr_perm = host_may_write(cmd_e'(cmd));
        rd_perm = host_may_read(cmd_e'(cmd));
        // the engine owns the queue in any cycle it strobes
        wr_try  = host_wr & ~eng_act;
        rd_try  = host_rd & ~eng_act;
        lost    = eng_act & (host_wr | host_rd);
    end
endmodule

// File: rtl/shfifo_mem.sv
module shfifo_mem #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] cell_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (we && waddr == AW'(i)) cell_q[i] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/shfifo_top.sv
module shfifo_top
    import shfifo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [2:0]    cmd,
    input  logic          host_wr,
    input  logic [W-1:0]  host_wdata,
    input  logic          host_rd,
    output logic [W-1:0]  host_rdata,
    input  logic          eng_push,
    input  logic [W-1:0]  eng_wdata,
    input  logic          eng_pop,
    output logic [W-1:0]  eng_rdata,
    output logic [PW-1:0] fifo_len,
    output logic          overflow,
    output logic          conflict
);
    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic          ovf;
        logic          cfl;
    } state_t;

    state_t st_d, st_q;

    logic wr_try, rd_try, wr_perm, rd_perm, lost;
    logic full, empty, do_push, do_pop, ovf_set;
    logic [PW-1:0] count;
    logic [W-1:0]  head, push_data;

    shfifo_gate u_gate (
        .cmd      (cmd),
        .host_wr  (host_wr),
        .host_rd  (host_rd),
        .eng_push (eng_push),
        .eng_pop  (eng_pop),
        .wr_try   (wr_try),
        .rd_try   (rd_try),
        .wr_perm  (wr_perm),
        .rd_perm  (rd_perm),
        .lost     (lost)
    );

    shfifo_mem #(.DEPTH(DEPTH), .W(W)) u_mem (
        .clk   (clk),
        .we    (do_push),
        .waddr (st_q.wptr[AW-1:0]),
        .wdata (push_data),
        .raddr (st_q.rptr[AW-1:0]),
        .rdata (head)
    );

    always_comb begin
        count     = st_q.wptr - st_q.rptr;
        full      = (count == PW'(DEPTH));
        empty     = (count == '0);
        push_data = eng_push ? eng_wdata : host_wdata;
        do_push   = ~flush & ~full & (eng_push | (wr_try & wr_perm));
        do_pop    = ~flush & ~empty & (eng_pop | (rd_try & rd_perm));
        ovf_set   = ~flush & ((eng_push & full) | (wr_try & (~wr_perm | full)));

        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wptr = st_q.wptr + 1'b1;
            if (do_pop)  st_d.rptr = st_q.rptr + 1'b1;
            if (ovf_set) st_d.ovf  = 1'b1;
            if (lost)    st_d.cfl  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign host_rdata = (~flush & rd_try & rd_perm & ~empty) ? head : '0;
    assign eng_rdata  = empty ? '0 : head;
    assign fifo_len   = count;
    assign overflow   = st_q.ovf;
    assign conflict   = st_q.cfl;

    // R5: length never exceeds capacity
    a_r5_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_len <= PW'(DEPTH));

    // R6: a full queue that is not drained stays full
    a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_len == PW'(DEPTH) && !flush && !eng_pop && !host_rd) |=> fifo_len == PW'(DEPTH));

    // R6: overflow is sticky until flush
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !flush) |=> overflow);

    // R10: flush empties and clears flags
    a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fifo_len == '0 && !overflow && !conflict));

    // R3: a read under a non-reading command yields zero
    a_r3_blocked_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && cmd != 3'd3 && cmd != 3'd4) |-> host_rdata == '0);

    // R9: host access beside an engine strobe raises conflict
    a_r9_conflict_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((eng_push || eng_pop) && (host_wr || host_rd) && !flush) |=> conflict);

    // R7: reading an empty queue with no push leaves it empty
    a_r7_empty_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_len == '0 && !eng_push && !host_wr) |=> fifo_len == '0);
endmodule

// File: tb/shfifo_top_bench.sv
`timescale 1ns/1ps
module shfifo_top_bench;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic       host_wr = 1'b0, host_rd = 1'b0, eng_push = 1'b0, eng_pop = 1'b0;
    logic [7:0] host_wdata = '0, eng_wdata = '0;
    logic [7:0] host_rdata, eng_rdata;
    logic [6:0] fifo_len;
    logic       overflow, conflict;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    shfifo_top u_shfifo_top (
        .clk(clk), .rst_n(rst_n), .flush(flush), .cmd(cmd),
        .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata),
        .eng_push(eng_push), .eng_wdata(eng_wdata),
        .eng_pop(eng_pop), .eng_rdata(eng_rdata),
        .fifo_len(fifo_len), .overflow(overflow), .conflict(conflict)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    task automatic hwrite(logic [2:0] c, logic [7:0] d);
        @(negedge clk); cmd = c; host_wr = 1'b1; host_wdata = d;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic hread(logic [2:0] c, output logic [7:0] d);
        @(negedge clk); cmd = c; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk); host_rd = 1'b0;
    endtask

    task automatic epush(logic [7:0] d);
        @(negedge clk); eng_push = 1'b1; eng_wdata = d;
        @(negedge clk); eng_push = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 len", fifo_len, 0);
        chk("R1 overflow", overflow, 0);
        chk("R1 conflict", conflict, 0);
    endtask

    task automatic t_order();
        logic [7:0] d;
        do_flush();
        hwrite(3'd2, 8'hA1); hwrite(3'd2, 8'hB2); hwrite(3'd2, 8'hC3);
        chk("R5 len after 3", fifo_len, 3);
        hread(3'd3, d); chk("R4 first", d, 8'hA1);
        hread(3'd3, d); chk("R4 second", d, 8'hB2);
        hread(3'd3, d); chk("R4 third", d, 8'hC3);
        chk("R5 len drained", fifo_len, 0);
    endtask

    task automatic t_write_perm();
        for (int c = 0; c < 8; c++) begin
            bit ok = (c == 2 || c == 4 || c == 5);
            do_flush();
            hwrite(3'(c), 8'h5A);
            chk($sformatf("R2 len cmd%0d", c), fifo_len, ok ? 1 : 0);
            chk($sformatf("R2 ovf cmd%0d", c), overflow, ok ? 0 : 1);
        end
    endtask

    task automatic t_read_perm();
        logic [7:0] d;
        do_flush();
        epush(8'h3C);
        for (int c = 0; c < 8; c++) begin
            if (c == 3 || c == 4) continue;
            hread(3'(c), d);
            chk($sformatf("R3 data cmd%0d", c), d, 0);
            chk($sformatf("R3 len cmd%0d", c), fifo_len, 1);
        end
        hread(3'd4, d);
        chk("R3 granted data", d, 8'h3C);
        chk("R3 granted len", fifo_len, 0);
    endtask

    task automatic t_empty();
        logic [7:0] d;
        do_flush();
        hread(3'd3, d);
        chk("R7 data", d, 0);
        chk("R7 len", fifo_len, 0);
        chk("R7 ovf", overflow, 0);
        chk("R7 cfl", conflict, 0);
    endtask

    task automatic t_full();
        logic [7:0] d;
        do_flush();
        for (int i = 0; i < DEPTH; i++) hwrite(3'd2, 8'(i));
        chk("R5 full len", fifo_len, DEPTH);
        chk("R6 no ovf yet", overflow, 0);
        hwrite(3'd2, 8'hEE);
        chk("R6 len after overflow", fifo_len, DEPTH);
        chk("R6 ovf set", overflow, 1);
        epush(8'hEF);
        chk("R6 engine push full len", fifo_len, DEPTH);
        for (int i = 0; i < DEPTH; i++) begin
            hread(3'd3, d);
            if (d != 8'(i)) chk("R4 full drain", d, i);
        end
        chk("R6 drained len", fifo_len, 0);
        chk("R6 ovf sticky", overflow, 1);
    endtask

    task automatic t_engine();
        do_flush();
        cmd = 3'd0;
        epush(8'h11); epush(8'h22);
        chk("R8 idle push len", fifo_len, 2);
        chk("R8 peek", eng_rdata, 8'h11);
        @(negedge clk); eng_pop = 1'b1;
        @(negedge clk); eng_pop = 1'b0;
        chk("R8 pop len", fifo_len, 1);
        chk("R8 peek next", eng_rdata, 8'h22);
        @(negedge clk); cmd = 3'd1; eng_pop = 1'b1;
        @(negedge clk); eng_pop = 1'b0;
        chk("R8 startup pop", fifo_len, 0);
        chk("R8 empty peek", eng_rdata, 0);
    endtask

    task automatic t_conflict();
        logic [7:0] d;
        do_flush();
        @(negedge clk); cmd = 3'd2; eng_push = 1'b1; eng_wdata = 8'h55;
        host_wr = 1'b1; host_wdata = 8'h66;
        @(negedge clk); eng_push = 1'b0; host_wr = 1'b0;
        chk("R9 len", fifo_len, 1);
        chk("R9 conflict", conflict, 1);
        chk("R9 no ovf", overflow, 0);
        @(negedge clk); cmd = 3'd3; eng_push = 1'b1; eng_wdata = 8'h77; host_rd = 1'b1;
        #1 chk("R9 read data zero", host_rdata, 0);
        @(negedge clk); eng_push = 1'b0; host_rd = 1'b0;
        chk("R9 read ignored len", fifo_len, 2);
        hread(3'd3, d); chk("R9 engine byte kept", d, 8'h55);
        hread(3'd3, d); chk("R9 second engine byte", d, 8'h77);
    endtask

    task automatic t_flush();
        epush(8'h01); epush(8'h02);
        hwrite(3'd0, 8'h03);
        @(negedge clk); flush = 1'b1; cmd = 3'd2; host_wr = 1'b1; host_wdata = 8'h99;
        @(negedge clk); flush = 1'b0; host_wr = 1'b0;
        chk("R10 len", fifo_len, 0);
        chk("R10 ovf", overflow, 0);
        chk("R10 cfl", conflict, 0);
    endtask

    task automatic t_wrap();
        logic [7:0] d;
        int bad = 0;
        do_flush();
        for (int i = 0; i < 40; i++) hwrite(3'd5, 8'(i));
        for (int i = 0; i < 40; i++) begin hread(3'd4, d); if (d != 8'(i)) bad++; end
        for (int i = 0; i < 40; i++) hwrite(3'd4, 8'(100 + i));
        chk("R11 len after wrap", fifo_len, 40);
        for (int i = 0; i < 40; i++) begin hread(3'd4, d); if (d != 8'(100 + i)) bad++; end
        chk("R11 mismatches", bad, 0);
        chk("R11 final len", fifo_len, 0);
    endtask

    initial begin
        #1 chk("R1 len at time zero", fifo_len, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_write_perm();
        t_read_perm();
        t_empty();
        t_full();
        t_engine();
        t_conflict();
        t_flush();
        t_wrap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #500000;
        checks++; errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule